// File: doc/BRIEF.md
# Byte-Lane Synchronous SRAM Core

This block is a small single-port synchronous memory. Its word is split into byte lanes, each written under its own control. An edge-sampled command can read, write or deselect the array. Writes are qualified either by one global-write control that stores the whole word, or by a byte-write enable gated per lane by that lane's select. Reads leave the block either straight from the array or through an extra rising-edge output register. The flow-through input picks between the two at run time.

The output bus is modelled as a data word plus a valid flag. A high-impedance bus shows as a low flag and an all-zero data word. A deselect turns the bus off one pipeline stage sooner than a read turns it on: the bus goes quiet right after the edge that captures the deselect. Output enable and sleep bypass the clock. Sleep also blocks all accesses and keeps the stored words. The address comes from an external burst counter.

Top module: `sbw_sram`

## Requirements
- R1: While reset is low and directly after it, the bus is off: rd_valid is 0 and rd_data is all zeros. Whenever rd_valid is 0, rd_data is all zeros.
- R2: The chip is selected at an edge only when ce0_n is 0, ce1 is 1 and ce2_n is 0. At any other edge nothing is written and the command counts as a deselect.
- R3: At a selected edge with gw_n low, all lanes of the word at addr take wdata, whatever bw_n and bsel_n are.
- R4: With gw_n high and bw_n low, lane i (bits 9i+8 down to 9i of the 36-bit word) is written only when bsel_n[i] is 0. Any set of lanes may be written at once, and the other lanes keep their contents.
- R5: A selected edge with bw_n low and no bsel_n bit low changes no stored bit and is not a read.
- R6: With flow_n low, a read captured at edge N drives rd_valid high and rd_data to the word stored at that address, starting right after edge N.
- R7: With flow_n high, a read captured at edge N is shown right after edge N+1. The value shown is the word held at that address just before edge N+1.
- R8: A deselect captured at edge M turns the bus off right after M in both modes, including when a pipelined read result would otherwise appear at M.
- R9: oe_n high turns the bus off at once, without waiting for a clock edge. Lowering it brings the pending read data back.
- R10: sleep high turns the bus off at once. Edges taken during sleep write nothing and capture no read, and all stored words are retained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of the control stages |
| addr | input | AW (8) | Word address from the burst counter |
| wdata | input | DATA_W (36) | Write data, four 9-bit lanes |
| ce0_n | input | 1 | Chip enable, active low |
| ce1 | input | 1 | Chip enable, active high |
| ce2_n | input | 1 | Chip enable, active low |
| bw_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | LANES (4) | Per-lane write selects, active low |
| gw_n | input | 1 | Global write of all lanes, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep, active high |
| flow_n | input | 1 | 0 = flow-through read, 1 = pipelined read |
| rd_data | output | DATA_W (36) | Read data, zero when the bus is off |
| rd_valid | output | 1 | Bus driven flag |

## Verification
The bench builds the block with its defaults: 256 words of four 9-bit lanes. Random traffic stays within the lowest 16 addresses, so reads often land on words that were just written, and pipelined reads can meet a write to the same word one edge later. The flow-through input, output enable and sleep are switched between cycles during random traffic. This reaches mode changes in mid-stream, deselects that cut off a pipelined result, and sleep windows that hide writes.

// File: rtl/sbw_pkg.sv
package sbw_pkg;

   typedef enum logic [1:0] {
      SBW_IDLE  = 2'd0,
      SBW_READ  = 2'd1,
      SBW_WRITE = 2'd2
   } sbw_cmd_e;

   function automatic logic sbw_all_enabled(input logic e0_n, input logic e1, input logic e2_n);
      return !e0_n && e1 && !e2_n;
   endfunction

endpackage

// File: rtl/sbw_cmd_decode.sv
module sbw_cmd_decode
   import sbw_pkg::*;
#(
   parameter int LANES = 4
) (
   input  logic             ce0_n,
   input  logic             ce1,
   input  logic             ce2_n,
   input  logic             sleep,
   input  logic             gw_n,
   input  logic             bw_n,
   input  logic [LANES-1:0] bsel_n,
   output logic             sel_ok,
   output sbw_cmd_e         cmd,
   output logic [LANES-1:0] lane_we
);

   assign sel_ok = sbw_all_enabled(ce0_n, ce1, ce2_n) && !sleep;

   // Global write overrides the per-lane qualification
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_we[g] = sel_ok && (!gw_n || (!bw_n && !bsel_n[g]));
   end

   always_comb begin
      if (!sel_ok)
         cmd = SBW_IDLE;
      else if (!gw_n || !bw_n)
         cmd = SBW_WRITE;
      else
         cmd = SBW_READ;
   end

endmodule

// File: rtl/sbw_lane_store.sv
module sbw_lane_store #(
   parameter int LANES  = 4,
   parameter int LANE_W = 9,
   parameter int DEPTH  = 256,
   localparam int DATA_W = LANES * LANE_W,
   localparam int AW     = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic [LANES-1:0]  lane_we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] cells [DEPTH];

      always_ff @(posedge clk) begin
         if (lane_we[g])
            cells[waddr] <= wdata[g*LANE_W +: LANE_W];
      end

      assign rdata[g*LANE_W +: LANE_W] = cells[raddr];
   end

endmodule

// File: rtl/sbw_read_path.sv
module sbw_read_path #(
   parameter int DATA_W = 36
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_q,
   input  logic              desel_q,
   input  logic              flow_n,
   input  logic              oe_n,
   input  logic              sleep,
   input  logic [DATA_W-1:0] arr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid
);

   logic              pv_q;
   logic [DATA_W-1:0] dout_q;
   logic              drive;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pv_q   <= 1'b0;
         dout_q <= '0;
      end else begin
         pv_q   <= rd_q;
         dout_q <= arr_data;
      end
   end

   // Deselect acts from the input stage in both modes
   assign drive    = flow_n ? (pv_q && !desel_q) : rd_q;
   assign rd_valid = drive && !oe_n && !sleep;
   assign rd_data  = rd_valid ? (flow_n ? dout_q : arr_data) : '0;

endmodule

// File: rtl/sbw_sram.sv
module sbw_sram
   import sbw_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int LANE_W = 9,
   parameter int DEPTH  = 256,
   localparam int DATA_W = LANES * LANE_W,
   localparam int AW     = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AW-1:0]     addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              ce0_n,
   input  logic              ce1,
   input  logic              ce2_n,
   input  logic              bw_n,
   input  logic [LANES-1:0]  bsel_n,
   input  logic              gw_n,
   input  logic              oe_n,
   input  logic              sleep,
   input  logic              flow_n,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid
);

   if (LANES < 1) begin : g_bad_lanes
      $error("sbw_sram: LANES must be at least 1");
   end
   if (LANE_W < 1) begin : g_bad_lane_w
      $error("sbw_sram: LANE_W must be at least 1");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("sbw_sram: DEPTH must be a power of two, at least 2");
   end

   logic              sel_ok;
   sbw_cmd_e          cmd;
   logic [LANES-1:0]  lane_we;
   logic [AW-1:0]     addr_q;
   logic              rd_q;
   logic              desel_q;
   logic [DATA_W-1:0] arr_data;

   sbw_cmd_decode #(.LANES(LANES)) u_dec (
      .ce0_n   (ce0_n),
      .ce1     (ce1),
      .ce2_n   (ce2_n),
      .sleep   (sleep),
      .gw_n    (gw_n),
      .bw_n    (bw_n),
      .bsel_n  (bsel_n),
      .sel_ok  (sel_ok),
      .cmd     (cmd),
      .lane_we (lane_we)
   );

   // Input register stage
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q  <= '0;
         rd_q    <= 1'b0;
         desel_q <= 1'b1;
      end else begin
         addr_q  <= addr;
         rd_q    <= (cmd == SBW_READ);
         desel_q <= !sel_ok;
      end
   end

   sbw_lane_store #(.LANES(LANES), .LANE_W(LANE_W), .DEPTH(DEPTH)) u_store (
      .clk     (clk),
      .lane_we (lane_we),
      .waddr   (addr),
      .wdata   (wdata),
      .raddr   (addr_q),
      .rdata   (arr_data)
   );

   sbw_read_path #(.DATA_W(DATA_W)) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_q     (rd_q),
      .desel_q  (desel_q),
      .flow_n   (flow_n),
      .oe_n     (oe_n),
      .sleep    (sleep),
      .arr_data (arr_data),
      .rd_data  (rd_data),
      .rd_valid (rd_valid)
   );

endmodule

// File: rtl/sbw_sram_chk.sv
module sbw_sram_chk #(
   parameter int DATA_W = 36
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce0_n,
   input logic              ce1,
   input logic              ce2_n,
   input logic              bw_n,
   input logic              gw_n,
   input logic              oe_n,
   input logic              sleep,
   input logic              flow_n,
   input logic [DATA_W-1:0] rd_data,
   input logic              rd_valid
);

   logic sel_in;
   logic rd_cmd;
   assign sel_in = !ce0_n && ce1 && !ce2_n && !sleep;
   assign rd_cmd = sel_in && gw_n && bw_n;

   p_off_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |-> (rd_data == '0));

   p_desel_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(sel_in)) |-> !rd_valid);

   p_oe_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !rd_valid);

   p_sleep_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> !rd_valid);

   p_flow_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(rd_cmd) && !flow_n && !oe_n && !sleep) |-> rd_valid);

   p_pipe_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n, 2) && $past(rst_n) && $past(rd_cmd, 2) && $past(sel_in)
       && flow_n && !oe_n && !sleep) |-> rd_valid);

endmodule

bind sbw_sram sbw_sram_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sbw_sram_test.sv
`timescale 1ns/1ps
module sbw_sram_test;

   localparam int LANES = 4;
   localparam int LW    = 9;
   localparam int DEPTH = 256;
   localparam int DW    = LANES * LW;
   localparam int AW    = 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [AW-1:0] addr;
   logic [DW-1:0] wdata;
   logic          ce0_n, ce1, ce2_n, bw_n, gw_n, oe_n, sleep, flow_n;
   logic [3:0]    bsel_n;
   logic [DW-1:0] rd_data;
   logic          rd_valid;

   int checks = 0;
   int fails  = 0;

   // bench model of the requirements
   logic [DW-1:0] m_mem [DEPTH];
   logic          e_rd, e_pv, e_desel;
   logic [DW-1:0] e_pdata;
   logic [AW-1:0] e_addr;

   always #2 clk = ~clk;

   sbw_sram uut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
      .ce0_n(ce0_n), .ce1(ce1), .ce2_n(ce2_n), .bw_n(bw_n), .bsel_n(bsel_n),
      .gw_n(gw_n), .oe_n(oe_n), .sleep(sleep), .flow_n(flow_n),
      .rd_data(rd_data), .rd_valid(rd_valid)
   );

   function automatic logic [DW-1:0] pat(input int a, input int salt);
      return {4{9'(a * 37 + salt * 11 + 5)}};
   endfunction

   function automatic logic exp_valid();
      logic drv;
      drv = flow_n ? (e_pv && !e_desel) : e_rd;
      return drv && !oe_n && !sleep;
   endfunction

   function automatic logic [DW-1:0] exp_data();
      if (!exp_valid()) return '0;
      return flow_n ? e_pdata : m_mem[e_addr];
   endfunction

   task automatic check(input string tag);
      logic          ev;
      logic [DW-1:0] ed;
      ev = exp_valid();
      ed = exp_data();
      checks++;
      if (rd_valid !== ev || rd_data !== ed) begin
         fails++;
         $display("FAIL %s: valid=%b data=%h expected valid=%b data=%h",
                  tag, rd_valid, rd_data, ev, ed);
      end
   endtask

   // kind: 0 deselect, 1 read, 2 global write, 3 byte write, 4 no-lane byte write
   task automatic drive(input int kind, input int a, input logic [DW-1:0] d, input logic [3:0] bs);
      ce0_n  = 1'b0; ce1 = (kind != 0); ce2_n = 1'b0;
      addr   = AW'(a);
      wdata  = d;
      gw_n   = !(kind == 2);
      bw_n   = !(kind == 3 || kind == 4);
      bsel_n = (kind == 4) ? 4'b1111 : bs;
   endtask

   task automatic tick(input string tag);
      logic sel;
      @(posedge clk);
      if (!rst_n) begin
         e_rd = 1'b0; e_pv = 1'b0; e_desel = 1'b1; e_pdata = '0; e_addr = '0;
      end else begin
         sel     = !ce0_n && ce1 && !ce2_n && !sleep;
         e_pdata = m_mem[e_addr];
         e_pv    = e_rd;
         if (sel) begin
            for (int l = 0; l < LANES; l++)
               if (!gw_n || (!bw_n && !bsel_n[l]))
                  m_mem[addr][l*LW +: LW] = wdata[l*LW +: LW];
         end
         e_rd    = sel && gw_n && bw_n;
         e_desel = !sel;
         e_addr  = addr;
      end
      @(negedge clk);
      check(tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int seed_dummy;
      seed_dummy = $urandom(32'd4242);
      rst_n = 1'b0; oe_n = 1'b0; sleep = 1'b0; flow_n = 1'b0;
      drive(0, 0, '0, 4'hF);
      e_rd = 1'b0; e_pv = 1'b0; e_desel = 1'b1; e_pdata = '0; e_addr = '0;
      @(negedge clk);
      check("R1 in reset");
      tick("R1 in reset");
      tick("R1 in reset");
      rst_n = 1'b1;
      tick("R1 after reset");

      // R3: global write fills words 0..15 with mixed lane selects
      for (int a = 0; a < 16; a++) begin
         drive(2, a, pat(a, 0), 4'(a));
         bw_n = a[0];
         tick("R3 global write");
      end
      // R6: flow-through read-back, back to back
      for (int a = 0; a < 16; a++) begin
         drive(1, a, '0, 4'hF);
         tick("R3/R6 flow read");
      end

      // R4: lanes 0 and 2 at word 3
      drive(3, 3, {4{9'h1AB}}, 4'b1010);
      tick("R4 byte write");
      drive(1, 3, '0, 4'hF);
      tick("R4 merged lanes");
      drive(3, 3, {4{9'h0F0}}, 4'b0110);
      tick("R4 byte write");
      drive(1, 3, '0, 4'hF);
      tick("R4 merged lanes");

      // R5: byte write with no lane selected
      drive(4, 4, '1, 4'hF);
      tick("R5 no-lane write is not a read");
      drive(1, 4, '0, 4'hF);
      tick("R5 word unchanged");

      // R2: each enable inactive blocks a global write and a read
      for (int k = 0; k < 3; k++) begin
         drive(2, 5, '1, 4'h0);
         if (k == 0) ce0_n = 1'b1;
         if (k == 1) ce1 = 1'b0;
         if (k == 2) ce2_n = 1'b1;
         tick("R2 unselected write");
         drive(1, 5, '0, 4'hF);
         if (k == 2) ce0_n = 1'b1;
         tick("R2 unselected read");
      end
      drive(1, 5, '0, 4'hF);
      tick("R2 word 5 kept");

      // R7: pipelined timing and read-before-write on the same word
      flow_n = 1'b1;
      drive(4, 0, '0, 4'hF);
      tick("R7 pipe idle");
      drive(1, 6, '0, 4'hF);
      tick("R7 not yet shown");
      drive(2, 6, pat(6, 9), 4'hF);
      tick("R7 old word after N+1");
      drive(1, 6, '0, 4'hF);
      tick("R7 pipe");
      drive(4, 0, '0, 4'hF);
      tick("R7 new word shown");

      // R8: deselect kills a pipelined result due at the same edge
      drive(1, 7, '0, 4'hF);
      tick("R8 pipe read");
      drive(0, 0, '0, 4'hF);
      tick("R8 deselect pipe");
      flow_n = 1'b0;
      drive(1, 8, '0, 4'hF);
      tick("R8 flow read");
      drive(0, 0, '0, 4'hF);
      tick("R8 deselect flow");

      // R9: output enable acts between edges
      flow_n = 1'b1;
      drive(1, 9, '0, 4'hF);
      tick("R9 setup");
      drive(4, 0, '0, 4'hF);
      tick("R9 shown");
      oe_n = 1'b1; #1 check("R9 oe high");
      oe_n = 1'b0; #1 check("R9 oe low again");

      // R10: sleep acts at once, blocks writes, keeps contents
      sleep = 1'b1; #1 check("R10 sleep off");
      drive(2, 10, '0, 4'h0);
      tick("R10 write in sleep");
      drive(1, 10, '0, 4'hF);
      tick("R10 read in sleep");
      sleep = 1'b0;
      flow_n = 1'b0;
      drive(1, 10, '0, 4'hF);
      tick("R10 contents retained");
      drive(1, 11, '0, 4'hF);
      tick("R10 contents retained");

      // random traffic
      for (int i = 0; i < 4000; i++) begin
         int r;
         r = int'($urandom % 10);
         drive((r < 2) ? 0 : (r < 6) ? 1 : (r == 6) ? 2 : (r == 7) ? 3 : (r == 8) ? 4 : 1,
               int'($urandom % 16), {$urandom, 4'($urandom)}, 4'($urandom));
         oe_n  = ($urandom % 8) == 0;
         sleep = ($urandom % 40) == 0;
         if (($urandom % 32) == 0) flow_n = !flow_n;
         tick("R6/R7 random");
      end

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule